// File: doc/BRIEF.md
# Command Byte Decoder with Configuration Registers

This block sits behind a serial receiver that has already assembled whole 8-bit command bytes, each delivered as a byte with a one-cycle valid. The position of the most significant set bit in a byte selects the kind of command. The remaining lower bits carry the fields written into that command's register, so the field space shrinks as the selecting prefix grows. Conversion, setup and averaging bytes load their registers. A reset byte returns every configuration register to its power-up value. DAC-select, no-operation and GPIO bytes only announce themselves.

Every accepted command raises exactly one bit of a one-hot strobe vector for one cycle, in the cycle after its byte. A GPIO write opens a data window of a parameterised length, one or two bytes. Bytes inside that window are passed out as data and are never decoded. A parameter removes GPIO support entirely, and the GPIO command codes are then ignored. The 12-bit DAC code register takes its default from a resolution-select input: all ones when the input is high, all zeros when it is low.

Top module: `cmd_decoder_top`

## Requirements
- R1: The command kind is selected by the most significant set bit. Bit 7 selects conversion (strobe bit 8), bit 6 setup (strobe bit 7), bit 5 averaging (strobe bit 6), bit 4 DAC-select (strobe bit 5) and bit 3 reset (strobe bit 4). No more than one strobe bit is ever high.
- R2: A conversion byte loads the channel from bits 6:3, the scan mode from bits 2:1 and the temperature flag from bit 0.
- R3: A setup byte loads the clock select from bits 5:4, the reference select from bits 3:2 and the differential select from bits 1:0. The setup register changes only on a setup or reset command.
- R4: An averaging byte loads the enable from bit 4, the averaging count from bits 3:2 and the repeat count from bits 1:0.
- R5: A reset byte stores its bit 2 as the reset flag, bit 1 as the slow flag and bit 0 as the bandgap-on flag. It returns the conversion, setup, averaging and DAC registers to their power-up values.
- R6: A DAC-select byte raises strobe bit 5 and changes no register, whatever its bits 3:0 hold.
- R7: A byte with bits 7:2 all zero decodes its low two bits: 00 is no-operation (strobe bit 0), 01 is GPIO read (bit 1), 10 is GPIO write (bit 2) and 11 is GPIO configure (bit 3). A byte with bits 7:3 zero and bit 2 set is ignored and raises no strobe.
- R8: With GPIO disabled, GPIO command bytes raise no strobe and open no data window.
- R9: After the synchronous reset, the conversion, averaging and reset-flag registers are zero. The setup register holds clock select 10, reference select 10 and differential select 00.
- R10: After reset or a reset command, the DAC code is 0xFFF if the resolution-select input is high at that edge and 0x000 if it is low.
- R11: A GPIO write sets the pending count to WR_BYTES (1 or 2). Each following valid byte decrements the count and appears on the data output with a one-cycle data strobe. No command strobe is raised for that byte and no register changes.
- R12: A strobe appears only in the cycle after a valid byte and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_i | input | 8 | Received command or data byte |
| byte_vld_i | input | 1 | byte_i is valid this cycle |
| res_sel_i | input | 1 | Resolution select, picks the DAC code default |
| cmd_stb_o | output | 9 | One-hot command strobe, bit index per R1/R7 |
| conv_chan_o | output | 4 | Conversion channel |
| conv_scan_o | output | 2 | Conversion scan mode |
| conv_temp_o | output | 1 | Temperature measurement flag |
| clk_sel_o | output | 2 | Clock select |
| ref_sel_o | output | 2 | Reference select |
| diff_sel_o | output | 2 | Differential select |
| avg_en_o | output | 1 | Averaging enable |
| avg_cnt_o | output | 2 | Averaging count select |
| avg_rpt_o | output | 2 | Scan repeat count select |
| rst_flag_o | output | 1 | Reset flag from the last reset byte |
| slow_o | output | 1 | Slow flag from the last reset byte |
| bg_on_o | output | 1 | Bandgap-on flag from the last reset byte |
| dac_code_o | output | DAC_W (12) | DAC code register |
| gpio_pend_o | output | 2 | GPIO data bytes still expected |
| gpio_data_o | output | 8 | Last GPIO data byte |
| gpio_data_stb_o | output | 1 | One-cycle pulse when a GPIO data byte arrives |

## Verification
The assertions assume that byte_vld_i and byte_i are stable and known at every clock edge after reset. They also assume that WR_BYTES is 1 or 2, so the pending count never wraps. The bench drives inputs only on falling edges and keeps every valid pulse a single cycle long, always followed by an idle cycle. Its random bytes are drawn per command class so that every prefix is exercised, GPIO writes included, and the data bytes that follow a write are themselves random command-looking bytes. The same byte stream also feeds a second instance built without GPIO support.

// File: rtl/cmd_pkg.sv
package cmd_pkg;

    localparam int KIND_N = 9;
    localparam int PEND_W = 2;

    typedef enum logic [3:0] {
        K_NOP   = 4'd0,
        K_GRD   = 4'd1,
        K_GWR   = 4'd2,
        K_GCFG  = 4'd3,
        K_RST   = 4'd4,
        K_DAC   = 4'd5,
        K_AVG   = 4'd6,
        K_SETUP = 4'd7,
        K_CONV  = 4'd8,
        K_NONE  = 4'd15
    } cmd_kind_e;

    typedef struct packed {
        logic [3:0] chan;
        logic [1:0] scan;
        logic       temp;
    } conv_t;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic [1:0] ref_sel;
        logic [1:0] diff_sel;
    } setup_t;

    typedef struct packed {
        logic       en;
        logic [1:0] cnt;
        logic [1:0] rpt;
    } avg_t;

    typedef struct packed {
        logic flag;
        logic slow;
        logic bg_on;
    } rstreg_t;

    localparam setup_t SETUP_DFLT = '{clk_sel: 2'b10, ref_sel: 2'b10, diff_sel: 2'b00};

    function automatic cmd_kind_e decode_kind(input logic [7:0] b, input logic gpio_en);
        cmd_kind_e k;
        casez (b)
            8'b1???????: k = K_CONV;
            8'b01??????: k = K_SETUP;
            8'b001?????: k = K_AVG;
            8'b0001????: k = K_DAC;
            8'b00001???: k = K_RST;
            8'b000001??: k = K_NONE;
            8'b00000000: k = K_NOP;
            default:     k = gpio_en ? cmd_kind_e'({2'b00, b[1:0]}) : K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [KIND_N-1:0] kind_onehot(input cmd_kind_e k);
        if (k == K_NONE) return '0;
        return KIND_N'(1) << k;
    endfunction

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
    import cmd_pkg::*;
#(
    parameter bit GPIO_EN = 1'b1
) (
    input  logic [7:0] byte_i,
    input  logic       vld_i,
    input  logic       data_phase_i,
    output cmd_kind_e  kind_o,
    output logic       acc_o
);

    always_comb begin
        kind_o = decode_kind(byte_i, GPIO_EN);
        acc_o  = vld_i && !data_phase_i && (kind_o != K_NONE);
    end

endmodule

// File: rtl/cmd_cfg_regs.sv
module cmd_cfg_regs
    import cmd_pkg::*;
#(
    parameter int DAC_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_sel_i,
    input  logic              acc_i,
    input  cmd_kind_e         kind_i,
    input  logic [6:0]        fld_i,
    output conv_t             conv_o,
    output setup_t            setup_o,
    output avg_t              avg_o,
    output rstreg_t           rstreg_o,
    output logic [DAC_W-1:0]  dac_o,
    output logic [KIND_N-1:0] stb_o
);

    conv_t             conv_q;
    setup_t            setup_q;
    avg_t              avg_q;
    rstreg_t           rstreg_q;
    logic [DAC_W-1:0]  dac_q;
    logic [KIND_N-1:0] stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q   <= '0;
            setup_q  <= SETUP_DFLT;
            avg_q    <= '0;
            rstreg_q <= '0;
            dac_q    <= {DAC_W{res_sel_i}};
            stb_q    <= '0;
        end else begin
            stb_q <= acc_i ? kind_onehot(kind_i) : '0;
            if (acc_i) begin
                case (kind_i)
                    K_CONV:  conv_q  <= conv_t'(fld_i);
                    K_SETUP: setup_q <= setup_t'(fld_i[5:0]);
                    K_AVG:   avg_q   <= avg_t'(fld_i[4:0]);
                    K_RST: begin
                        conv_q   <= '0;
                        setup_q  <= SETUP_DFLT;
                        avg_q    <= '0;
                        dac_q    <= {DAC_W{res_sel_i}};
                        rstreg_q <= rstreg_t'(fld_i[2:0]);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign conv_o   = conv_q;
    assign setup_o  = setup_q;
    assign avg_o    = avg_q;
    assign rstreg_o = rstreg_q;
    assign dac_o    = dac_q;
    assign stb_o    = stb_q;

    // R9: defaults present in the first cycle after reset is released
    a_r9_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (setup_q == SETUP_DFLT && conv_q == '0 && avg_q == '0 && rstreg_q == '0));

    // R3: setup register only moves on setup or reset commands
    a_r3_setup_hold: assert property (@(posedge clk) disable iff (rst)
        !(acc_i && (kind_i == K_SETUP || kind_i == K_RST)) |=> $stable(setup_q));

    // R6: DAC code only moves on a reset command
    a_r6_dac_hold: assert property (@(posedge clk) disable iff (rst)
        !(acc_i && kind_i == K_RST) |=> $stable(dac_q));

endmodule

// File: rtl/cmd_gpio_track.sv
module cmd_gpio_track
    import cmd_pkg::*;
#(
    parameter int WR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        byte_i,
    input  logic              vld_i,
    input  logic              wr_acc_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              data_phase_o,
    output logic [7:0]        data_o,
    output logic              data_stb_o
);

    localparam logic [PEND_W-1:0] PEND_LOAD = PEND_W'(WR_BYTES);

    logic [PEND_W-1:0] pend_q;
    logic [7:0]        data_q;
    logic              data_stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            data_q     <= '0;
            data_stb_q <= 1'b0;
        end else begin
            data_stb_q <= 1'b0;
            if (vld_i && pend_q != '0) begin
                pend_q     <= pend_q - 1'b1;
                data_q     <= byte_i;
                data_stb_q <= 1'b1;
            end else if (wr_acc_i) begin
                pend_q <= PEND_LOAD;
            end
        end
    end

    assign pend_o       = pend_q;
    assign data_phase_o = (pend_q != '0);
    assign data_o       = data_q;
    assign data_stb_o   = data_stb_q;

    // R11: pending count never exceeds the configured window
    a_r11_pend_max: assert property (@(posedge clk) disable iff (rst)
        pend_q <= PEND_LOAD);

    // R11: a byte inside the window counts down and is forwarded
    a_r11_count_down: assert property (@(posedge clk) disable iff (rst)
        (vld_i && pend_q != '0) |=> (data_stb_q && pend_q == $past(pend_q) - 1'b1));

endmodule

// File: rtl/cmd_decoder_top.sv
module cmd_decoder_top
    import cmd_pkg::*;
#(
    parameter bit GPIO_EN  = 1'b1,
    parameter int WR_BYTES = 2,
    parameter int DAC_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        byte_i,
    input  logic              byte_vld_i,
    input  logic              res_sel_i,
    output logic [KIND_N-1:0] cmd_stb_o,
    output logic [3:0]        conv_chan_o,
    output logic [1:0]        conv_scan_o,
    output logic              conv_temp_o,
    output logic [1:0]        clk_sel_o,
    output logic [1:0]        ref_sel_o,
    output logic [1:0]        diff_sel_o,
    output logic              avg_en_o,
    output logic [1:0]        avg_cnt_o,
    output logic [1:0]        avg_rpt_o,
    output logic              rst_flag_o,
    output logic              slow_o,
    output logic              bg_on_o,
    output logic [DAC_W-1:0]  dac_code_o,
    output logic [PEND_W-1:0] gpio_pend_o,
    output logic [7:0]        gpio_data_o,
    output logic              gpio_data_stb_o
);

    cmd_kind_e kind;
    logic      acc;
    logic      data_phase;
    conv_t     conv;
    setup_t    setup;
    avg_t      avg;
    rstreg_t   rstreg;

    cmd_classify #(.GPIO_EN(GPIO_EN)) u_cls (
        .byte_i       (byte_i),
        .vld_i        (byte_vld_i),
        .data_phase_i (data_phase),
        .kind_o       (kind),
        .acc_o        (acc)
    );

    cmd_cfg_regs #(.DAC_W(DAC_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .res_sel_i (res_sel_i),
        .acc_i     (acc),
        .kind_i    (kind),
        .fld_i     (byte_i[6:0]),
        .conv_o    (conv),
        .setup_o   (setup),
        .avg_o     (avg),
        .rstreg_o  (rstreg),
        .dac_o     (dac_code_o),
        .stb_o     (cmd_stb_o)
    );

    cmd_gpio_track #(.WR_BYTES(WR_BYTES)) u_gpio (
        .clk          (clk),
        .rst          (rst),
        .byte_i       (byte_i),
        .vld_i        (byte_vld_i),
        .wr_acc_i     (acc && kind == K_GWR),
        .pend_o       (gpio_pend_o),
        .data_phase_o (data_phase),
        .data_o       (gpio_data_o),
        .data_stb_o   (gpio_data_stb_o)
    );

    assign conv_chan_o = conv.chan;
    assign conv_scan_o = conv.scan;
    assign conv_temp_o = conv.temp;
    assign clk_sel_o   = setup.clk_sel;
    assign ref_sel_o   = setup.ref_sel;
    assign diff_sel_o  = setup.diff_sel;
    assign avg_en_o    = avg.en;
    assign avg_cnt_o   = avg.cnt;
    assign avg_rpt_o   = avg.rpt;
    assign rst_flag_o  = rstreg.flag;
    assign slow_o      = rstreg.slow;
    assign bg_on_o     = rstreg.bg_on;

    // R1: at most one command kind is announced per cycle
    a_r1_stb_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb_o));

    // R12: a strobe needs a valid byte one cycle earlier
    a_r12_stb_after_vld: assert property (@(posedge clk) disable iff (rst)
        (|cmd_stb_o) |-> $past(byte_vld_i));

    // R11: bytes inside the data window never act as commands
    a_r11_data_not_cmd: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_i && gpio_pend_o != '0) |=> (cmd_stb_o == '0));

    generate
        if (!GPIO_EN) begin : g_no_gpio
            // R8: no GPIO activity at all when GPIO is absent
            a_r8_no_gpio: assert property (@(posedge clk) disable iff (rst)
                (cmd_stb_o[3:1] == 3'b000) && (gpio_pend_o == '0));
        end
    endgenerate

endmodule

// File: tb/tb_cmd_decoder_top.sv
module tb_cmd_decoder_top;

    localparam int WR_BYTES = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  byte_i = '0;
    logic        byte_vld_i = 1'b0;
    logic        res_sel_i = 1'b1;

    logic [8:0]  cmd_stb;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_scan;
    logic        conv_temp;
    logic [1:0]  clk_sel, ref_sel, diff_sel;
    logic        avg_en;
    logic [1:0]  avg_cnt, avg_rpt;
    logic        rst_flag, slow, bg_on;
    logic [11:0] dac_code;
    logic [1:0]  gpio_pend;
    logic [7:0]  gpio_data;
    logic        gpio_data_stb;

    logic [8:0]  ng_stb;
    logic [3:0]  ng_chan;
    logic [1:0]  ng_scan;
    logic        ng_temp;
    logic [1:0]  ng_clk, ng_ref, ng_diff;
    logic        ng_aen;
    logic [1:0]  ng_acnt, ng_arpt;
    logic        ng_rflag, ng_slow, ng_bg;
    logic [11:0] ng_dac;
    logic [1:0]  ng_pend;
    logic [7:0]  ng_data;
    logic        ng_dstb;

    always #5 clk = ~clk;

    cmd_decoder_top #(.GPIO_EN(1'b1), .WR_BYTES(WR_BYTES), .DAC_W(12)) dut (
        .clk(clk), .rst(rst), .byte_i(byte_i), .byte_vld_i(byte_vld_i), .res_sel_i(res_sel_i),
        .cmd_stb_o(cmd_stb), .conv_chan_o(conv_chan), .conv_scan_o(conv_scan), .conv_temp_o(conv_temp),
        .clk_sel_o(clk_sel), .ref_sel_o(ref_sel), .diff_sel_o(diff_sel),
        .avg_en_o(avg_en), .avg_cnt_o(avg_cnt), .avg_rpt_o(avg_rpt),
        .rst_flag_o(rst_flag), .slow_o(slow), .bg_on_o(bg_on), .dac_code_o(dac_code),
        .gpio_pend_o(gpio_pend), .gpio_data_o(gpio_data), .gpio_data_stb_o(gpio_data_stb)
    );

    cmd_decoder_top #(.GPIO_EN(1'b0), .WR_BYTES(WR_BYTES), .DAC_W(12)) dut_nogpio (
        .clk(clk), .rst(rst), .byte_i(byte_i), .byte_vld_i(byte_vld_i), .res_sel_i(res_sel_i),
        .cmd_stb_o(ng_stb), .conv_chan_o(ng_chan), .conv_scan_o(ng_scan), .conv_temp_o(ng_temp),
        .clk_sel_o(ng_clk), .ref_sel_o(ng_ref), .diff_sel_o(ng_diff),
        .avg_en_o(ng_aen), .avg_cnt_o(ng_acnt), .avg_rpt_o(ng_arpt),
        .rst_flag_o(ng_rflag), .slow_o(ng_slow), .bg_on_o(ng_bg), .dac_code_o(ng_dac),
        .gpio_pend_o(ng_pend), .gpio_data_o(ng_data), .gpio_data_stb_o(ng_dstb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [3:0]  e_chan;
    logic [1:0]  e_scan;
    logic        e_temp;
    logic [1:0]  e_clk, e_ref, e_diff;
    logic        e_aen;
    logic [1:0]  e_acnt, e_arpt;
    logic        e_rflag, e_slow, e_bg;
    logic [11:0] e_dac;
    int          e_pend;
    logic [8:0]  e_stb;
    logic [7:0]  e_data;
    logic        e_dstb;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_index(input logic [7:0] b);
        for (int i = 7; i >= 3; i--)
            if (b[i]) return i + 1;
        if (b[2]) return -1;
        return int'(b[1:0]);
    endfunction

    task automatic model_defaults();
        e_chan = '0; e_scan = '0; e_temp = 1'b0;
        e_clk = 2'b10; e_ref = 2'b10; e_diff = 2'b00;
        e_aen = 1'b0; e_acnt = '0; e_arpt = '0;
        e_dac = {12{res_sel_i}};
    endtask

    task automatic model_step(input logic [7:0] b);
        int k;
        e_stb = '0;
        e_dstb = 1'b0;
        if (e_pend > 0) begin
            e_pend--;
            e_data = b;
            e_dstb = 1'b1;
        end else begin
            k = exp_index(b);
            if (k >= 0) e_stb[k] = 1'b1;
            case (k)
                8: begin e_chan = b[6:3]; e_scan = b[2:1]; e_temp = b[0]; end
                7: begin e_clk = b[5:4]; e_ref = b[3:2]; e_diff = b[1:0]; end
                6: begin e_aen = b[4]; e_acnt = b[3:2]; e_arpt = b[1:0]; end
                4: begin model_defaults(); e_rflag = b[2]; e_slow = b[1]; e_bg = b[0]; end
                2: e_pend = WR_BYTES;
                default: ;
            endcase
        end
    endtask

    task automatic check_regs();
        chk("R1/R7 strobe", 32'(cmd_stb), 32'(e_stb));
        chk("R2 conversion", {conv_chan, conv_scan, conv_temp}, {e_chan, e_scan, e_temp});
        chk("R3 setup", {clk_sel, ref_sel, diff_sel}, {e_clk, e_ref, e_diff});
        chk("R4 averaging", {avg_en, avg_cnt, avg_rpt}, {e_aen, e_acnt, e_arpt});
        chk("R5 reset flags", {rst_flag, slow, bg_on}, {e_rflag, e_slow, e_bg});
        chk("R10 dac code", 32'(dac_code), 32'(e_dac));
        chk("R11 pending", 32'(gpio_pend), 32'(e_pend));
        chk("R11 data strobe", 32'(gpio_data_stb), 32'(e_dstb));
        if (e_dstb) chk("R11 data byte", 32'(gpio_data), 32'(e_data));
        chk("R8 no gpio strobe", 32'(ng_stb[3:1]), 32'd0);
        chk("R8 no gpio window", 32'(ng_pend), 32'd0);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_i = b;
        byte_vld_i = 1'b1;
        @(posedge clk);
        model_step(b);
        @(negedge clk);
        byte_vld_i = 1'b0;
        byte_i = 8'($urandom);
        check_regs();
        @(negedge clk);
        chk("R12 strobe one cycle", 32'(cmd_stb), 32'd0);
        chk("R12 data strobe one cycle", 32'(gpio_data_stb), 32'd0);
    endtask

    function automatic logic [7:0] gen_byte();
        int k;
        logic [7:0] r;
        k = int'($urandom % 10);
        r = 8'($urandom);
        if (k >= 4 && k <= 8) return (8'd1 << (k - 1)) | (r & ((8'd1 << (k - 1)) - 8'd1));
        if (k == 9) return 8'h04 | (r & 8'h03);
        return 8'(k);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        e_rflag = 1'b0; e_slow = 1'b0; e_bg = 1'b0;
        e_pend = 0; e_stb = '0; e_data = '0; e_dstb = 1'b0;
        res_sel_i = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_defaults();
        @(negedge clk);
        // R9 and R10: power-up state
        chk("R9 setup default", {clk_sel, ref_sel, diff_sel}, 6'b10_10_00);
        chk("R9 conversion zero", {conv_chan, conv_scan, conv_temp}, 7'd0);
        chk("R9 averaging zero", {avg_en, avg_cnt, avg_rpt}, 5'd0);
        chk("R9 reset reg zero", {rst_flag, slow, bg_on}, 3'd0);
        chk("R10 dac default high", 32'(dac_code), 32'hFFF);
        check_regs();

        // directed corners
        send(8'h00);            // R7 no-op
        send(8'hB5);            // R2 conversion chan 6 scan 2 temp 1
        send(8'h7F);            // R3 setup
        send(8'h3B);            // R4 averaging
        send(8'h1F);            // R6 dac select, regs unchanged
        send(8'h05);            // R7 undefined prefix ignored
        res_sel_i = 1'b0;
        send(8'h0B);            // R5/R10 reset command, dac now 000
        chk("R10 dac after reset cmd", 32'(dac_code), 32'h000);
        chk("R5 setup restored", {clk_sel, ref_sel, diff_sel}, 6'b10_10_00);
        send(8'h02);            // R11 gpio write opens window
        send(8'h80);            // R11 data, not a conversion
        send(8'h08);            // R11 data, not a reset
        send(8'h03);            // R7 gpio configure
        send(8'h01);            // R7 gpio read
        res_sel_i = 1'b1;
        send(8'h0C);            // R5 reset with flag set

        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) res_sel_i = ~res_sel_i;
            send(gen_byte());
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule